// File: doc/BRIEF.md
# Mode-Aware Five-Pin GPIO Port

This block is a small general-purpose I/O port that sits on a microcontroller's peripheral bus. It has three bus-visible registers, each at its own fixed 16-bit address. The first is a direction register that can only be written. The second is an output data register that can be read and written. The third is a read-only view of the pin state. Every pin has an output enable and an output value, and each pin's input is brought in through a two-flop synchronizer.

The operating-mode input decides the power-on value of the direction bit of the top pin (pin 4). A separate manual-reset input clears the other state but leaves that bit as it was. When the mode selects an external bus, pin 4 stops carrying the data register bit. If its direction bit is set, it carries the chip-select signal that the bus controller supplies instead.

All resets are synchronous and active high. A write takes effect at the clock edge where the address matches and the write strobe is high. Read data is registered, so it appears one cycle after the strobe. It is zero in every cycle that does not follow a read.

Top module: `gpio_mode_port`

## Requirements
- R1: While `por_rst` is high at a clock edge, the following state is set. Direction bits 3..0 become 0, and the data register becomes 0x00. Direction bit 4 becomes 1 when `mode` is 1, 4 or 5, and 0 for any other mode value (0, 2, 3, 6, 7).
- R2: A clock edge with `man_rst` high (and `por_rst` low) clears direction bits 3..0 and the data register. It leaves direction bit 4 unchanged, and it ignores any bus write in that same cycle.
- R3: A write at address 0xFEBF loads `bus_wdata[4:0]` into the direction register at that edge. A read at that address returns a fixed pattern that carries no information.
- R4: A write at address 0xFF6F loads `bus_wdata[4:0]` into the data register. A read there returns the stored bits in positions 4..0, with bits 7..5 always 0.
- R5: For pins 3..0, `pin_oe[i]` equals direction bit i, and `pin_out[i]` equals data bit i.
- R6: `pin_oe[4]` equals direction bit 4 in every mode. In modes 1 through 6 (external bus), while direction bit 4 is 1, `pin_out[4]` equals `bus_cs_n`. Otherwise `pin_out[4]` equals data bit 4.
- R7: A read at address 0xFF5F returns a value built bit by bit. For a pin whose direction bit is 1, bit i is data bit i. For any other pin, bit i is the level of `pin_in[i]` delayed by the two-flop synchronizer. Bits 7..5 are 0.
- R8: `bus_rdata` holds the read result in the cycle after a read strobe. It is 0 in any cycle not preceded by a read, and 0 after a read of any other address.
- R9: If a read and a write to the same register fall in the same cycle, the read returns the contents from before the write.
- R10: A write to any address other than 0xFEBF and 0xFF6F leaves the outputs and the register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| man_rst | input | 1 | Manual reset, synchronous, active high |
| mode | input | 3 | Operating mode (0..7) |
| bus_addr | input | 16 | Lower 16 bits of the bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_cs_n | input | 1 | Chip-select level from the bus controller |
| pin_in | input | 5 | Pin input levels |
| pin_out | output | 5 | Pin output values |
| pin_oe | output | 5 | Pin output enables |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a register update and a register read. The bench puts the read and write strobes on the data address in the same cycle. It expects the old contents on `bus_rdata`, then the new contents on the next read.

The second pair is a manual reset and a bus write. The bench raises `man_rst` while writing a cleared direction pattern. It then judges two things at the ports: bit 4 of `pin_oe` must keep its earlier value, and pins 3..0 must be cleared.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DIR  = 2'd1,
      SEL_DAT  = 2'd2,
      SEL_PIN  = 2'd3
   } reg_sel_e;

   // power-on value of the mode-dependent direction bit
   function automatic logic mode_hold_bit_init(input logic [MODE_W-1:0] m);
      return (m == 3'd1) || (m == 3'd4) || (m == 3'd5);
   endfunction

   // modes in which the external bus, and thus chip select, is active
   function automatic logic mode_has_ext_bus(input logic [MODE_W-1:0] m);
      return (m >= 3'd1) && (m <= 3'd6);
   endfunction

endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
   import gpio_port_pkg::*;
#(
   parameter int                ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] DIR_ADDR = 16'hFEBF,
   parameter logic [ADDR_W-1:0] DAT_ADDR = 16'hFF6F,
   parameter logic [ADDR_W-1:0] PIN_ADDR = 16'hFF5F
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);

   if ((DIR_ADDR == DAT_ADDR) || (DIR_ADDR == PIN_ADDR) || (DAT_ADDR == PIN_ADDR)) begin : g_bad_map
      $error("gpio_port_decode: register addresses must be distinct");
   end

   always_comb begin
      if (addr == DIR_ADDR)      sel = SEL_DIR;
      else if (addr == DAT_ADDR) sel = SEL_DAT;
      else if (addr == PIN_ADDR) sel = SEL_PIN;
      else                       sel = SEL_NONE;
   end

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
   parameter int WIDTH  = 5,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("gpio_port_sync: STAGES must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst)         stage_q[s] <= '0;
         else if (s == 0) stage_q[s] <= d;
         else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
   parameter int PIN_COUNT = 5,
   parameter int HOLD_PIN  = 4
) (
   input  logic                 clk,
   input  logic                 por_rst,
   input  logic                 man_rst,
   input  logic                 hold_init,
   input  logic                 wr_dir,
   input  logic                 wr_dat,
   input  logic [PIN_COUNT-1:0] wdata,
   output logic [PIN_COUNT-1:0] dir_q,
   output logic [PIN_COUNT-1:0] dat_q
);

   if (HOLD_PIN >= PIN_COUNT) begin : g_bad_hold
      $error("gpio_port_regs: HOLD_PIN out of range");
   end

   for (genvar i = 0; i < PIN_COUNT; i++) begin : g_bit
      if (i == HOLD_PIN) begin : g_hold
         // survives manual reset; power-on value set by mode
         always_ff @(posedge clk) begin
            if (por_rst)      dir_q[i] <= hold_init;
            else if (man_rst) dir_q[i] <= dir_q[i];
            else if (wr_dir)  dir_q[i] <= wdata[i];
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (por_rst || man_rst) dir_q[i] <= 1'b0;
            else if (wr_dir)        dir_q[i] <= wdata[i];
         end
      end

      always_ff @(posedge clk) begin
         if (por_rst || man_rst) dat_q[i] <= 1'b0;
         else if (wr_dat)        dat_q[i] <= wdata[i];
      end
   end

endmodule

// File: rtl/gpio_port_pinmux.sv
module gpio_port_pinmux #(
   parameter int PIN_COUNT = 5,
   parameter int CS_PIN    = 4
) (
   input  logic [PIN_COUNT-1:0] dir_q,
   input  logic [PIN_COUNT-1:0] dat_q,
   input  logic [PIN_COUNT-1:0] pin_sync,
   input  logic                 ext_bus,
   input  logic                 cs_n,
   output logic [PIN_COUNT-1:0] pin_oe,
   output logic [PIN_COUNT-1:0] pin_out,
   output logic [PIN_COUNT-1:0] pin_view
);

   for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
      if (i == CS_PIN) begin : g_cs
         assign pin_out[i] = (ext_bus && dir_q[i]) ? cs_n : dat_q[i];
      end else begin : g_gp
         assign pin_out[i] = dat_q[i];
      end
      assign pin_oe[i]   = dir_q[i];
      assign pin_view[i] = dir_q[i] ? dat_q[i] : pin_sync[i];
   end

endmodule

// File: rtl/gpio_mode_port.sv
module gpio_mode_port
   import gpio_port_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter int                DATA_W      = 8,
   parameter int                PIN_COUNT   = 5,
   parameter int                SPECIAL_PIN = 4,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] DIR_ADDR    = 16'hFEBF,
   parameter logic [ADDR_W-1:0] DAT_ADDR    = 16'hFF6F,
   parameter logic [ADDR_W-1:0] PIN_ADDR    = 16'hFF5F,
   parameter logic [DATA_W-1:0] DIR_RD_FILL = 8'hFF
) (
   input  logic                 clk,
   input  logic                 por_rst,
   input  logic                 man_rst,
   input  logic [MODE_W-1:0]    mode,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic                 bus_cs_n,
   input  logic [PIN_COUNT-1:0] pin_in,
   output logic [PIN_COUNT-1:0] pin_out,
   output logic [PIN_COUNT-1:0] pin_oe
);

   if (PIN_COUNT >= DATA_W) begin : g_bad_width
      $error("gpio_mode_port: PIN_COUNT must leave reserved bits in DATA_W");
   end
   if (SPECIAL_PIN >= PIN_COUNT) begin : g_bad_special
      $error("gpio_mode_port: SPECIAL_PIN out of range");
   end

   reg_sel_e             sel;
   logic [PIN_COUNT-1:0] dir_q, dat_q, pin_sync, pin_view;
   logic [DATA_W-1:0]    rd_next;
   logic                 unused_wdata_hi;

   assign unused_wdata_hi = ^bus_wdata[DATA_W-1:PIN_COUNT];

   gpio_port_decode #(
      .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .DAT_ADDR(DAT_ADDR), .PIN_ADDR(PIN_ADDR)
   ) u_decode (
      .addr(bus_addr),
      .sel (sel)
   );

   gpio_port_regs #(
      .PIN_COUNT(PIN_COUNT), .HOLD_PIN(SPECIAL_PIN)
   ) u_regs (
      .clk      (clk),
      .por_rst  (por_rst),
      .man_rst  (man_rst),
      .hold_init(mode_hold_bit_init(mode)),
      .wr_dir   (bus_wr && (sel == SEL_DIR)),
      .wr_dat   (bus_wr && (sel == SEL_DAT)),
      .wdata    (bus_wdata[PIN_COUNT-1:0]),
      .dir_q    (dir_q),
      .dat_q    (dat_q)
   );

   gpio_port_sync #(
      .WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk(clk),
      .rst(por_rst),
      .d  (pin_in),
      .q  (pin_sync)
   );

   gpio_port_pinmux #(
      .PIN_COUNT(PIN_COUNT), .CS_PIN(SPECIAL_PIN)
   ) u_pinmux (
      .dir_q   (dir_q),
      .dat_q   (dat_q),
      .pin_sync(pin_sync),
      .ext_bus (mode_has_ext_bus(mode)),
      .cs_n    (bus_cs_n),
      .pin_oe  (pin_oe),
      .pin_out (pin_out),
      .pin_view(pin_view)
   );

   always_comb begin
      unique case (sel)
         SEL_DIR: rd_next = DIR_RD_FILL;
         SEL_DAT: rd_next = DATA_W'(dat_q);
         SEL_PIN: rd_next = DATA_W'(pin_view);
         default: rd_next = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (por_rst)     bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_next;
      else             bus_rdata <= '0;
   end

endmodule

// File: rtl/gpio_mode_port_chk.sv
module gpio_mode_port_chk
   import gpio_port_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 8,
   parameter int                PIN_COUNT = 5,
   parameter logic [ADDR_W-1:0] DIR_ADDR  = 16'hFEBF,
   parameter logic [ADDR_W-1:0] DAT_ADDR  = 16'hFF6F
) (
   input logic                 clk,
   input logic                 por_rst,
   input logic                 man_rst,
   input logic [MODE_W-1:0]    mode,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic                 bus_wr,
   input logic                 bus_rd,
   input logic [DATA_W-1:0]    bus_wdata,
   input logic [DATA_W-1:0]    bus_rdata,
   input logic                 bus_cs_n,
   input logic [PIN_COUNT-1:0] pin_in,
   input logic [PIN_COUNT-1:0] pin_out,
   input logic [PIN_COUNT-1:0] pin_oe
);

   logic por_d;
   logic unused_chk;
   assign unused_chk = ^pin_in;

   always_ff @(posedge clk) por_d <= por_rst;

   // R1: low direction bits cleared after power-on reset
   always_ff @(posedge clk) begin
      if (por_d === 1'b1 && por_rst === 1'b0)
         p_por_low_clear_r1: assert (pin_oe[PIN_COUNT-2:0] == '0 && pin_out[PIN_COUNT-2:0] == '0);
   end

   p_man_clear_r2: assert property (@(posedge clk) disable iff (por_rst)
      man_rst |=> pin_oe[PIN_COUNT-2:0] == '0);

   p_man_keep_r2: assert property (@(posedge clk) disable iff (por_rst)
      man_rst |=> pin_oe[PIN_COUNT-1] == $past(pin_oe[PIN_COUNT-1]));

   p_dir_write_r3: assert property (@(posedge clk) disable iff (por_rst)
      (bus_wr && bus_addr == DIR_ADDR && !man_rst) |=> pin_oe == $past(bus_wdata[PIN_COUNT-1:0]));

   p_reserved_zero_r4: assert property (@(posedge clk) disable iff (por_rst)
      (bus_rd && bus_addr == DAT_ADDR) |=> bus_rdata[DATA_W-1:PIN_COUNT] == '0);

   p_cs_route_r6: assert property (@(posedge clk) disable iff (por_rst)
      (mode_has_ext_bus(mode) && pin_oe[PIN_COUNT-1]) |-> pin_out[PIN_COUNT-1] == bus_cs_n);

   p_idle_zero_r8: assert property (@(posedge clk) disable iff (por_rst)
      !bus_rd |=> bus_rdata == '0);

endmodule

bind gpio_mode_port gpio_mode_port_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIN_COUNT(PIN_COUNT),
   .DIR_ADDR(DIR_ADDR), .DAT_ADDR(DAT_ADDR)
) u_chk (.*);

// File: tb/tb_gpio_mode_port.sv
module tb_gpio_mode_port;

   logic       clk = 1'b0;
   logic       por_rst = 1'b1;
   logic       man_rst = 1'b0;
   logic [2:0] mode = 3'd7;
   logic [15:0] bus_addr = 16'h0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'h0;
   logic [7:0] bus_rdata;
   logic       bus_cs_n = 1'b1;
   logic [4:0] pin_in = 5'h0;
   logic [4:0] pin_out;
   logic [4:0] pin_oe;

   localparam logic [15:0] A_DIR = 16'hFEBF;
   localparam logic [15:0] A_DAT = 16'hFF6F;
   localparam logic [15:0] A_PIN = 16'hFF5F;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [7:0] rv;

   always #2 clk = ~clk;

   gpio_mode_port dut (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic hi_init(input logic [2:0] m);
      return (m == 3'd1) || (m == 3'd4) || (m == 3'd5);
   endfunction

   task automatic do_por(input logic [2:0] m);
      @(negedge clk);
      mode = m; por_rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      por_rst = 1'b0;
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   initial begin
      // R1: power-on value of every mode
      for (int m = 0; m < 8; m++) begin
         do_por(3'(m));
         check("R1 oe after por", {27'd0, pin_oe}, {27'd0, hi_init(3'(m)), 4'b0000});
         rd(A_DAT, rv);
         check("R1 data after por", {24'd0, rv}, 32'd0);
         rd(A_DIR, rv); // R3: fixed pattern, value not checked
         @(negedge clk);
         check("R8 idle rdata zero", {24'd0, bus_rdata}, 32'd0);
      end

      // R3 R5: direction and data sweep in single-chip mode
      do_por(3'd7);
      for (int d = 0; d < 32; d++) begin
         logic [4:0] v;
         v = 5'((d * 7 + 3) & 31);
         wr(A_DIR, 8'(d) | 8'hE0);
         check("R3 dir write", {27'd0, pin_oe}, 32'(d));
         wr(A_DAT, {3'b111, v});
         check("R5 pin_out follows data", {27'd0, pin_out}, {27'd0, v});
         check("R5 oe unchanged by data", {27'd0, pin_oe}, 32'(d));
      end

      // R4: data register readback across all byte values
      for (int v = 0; v < 256; v++) begin
         wr(A_DAT, 8'(v));
         rd(A_DAT, rv);
         check("R4 data readback", {24'd0, rv}, 32'(v & 31));
      end

      // R7: pin-state view for several direction patterns
      wr(A_DAT, 8'h0A);
      for (int k = 0; k < 4; k++) begin
         logic [4:0] dpat;
         dpat = (k == 0) ? 5'h00 : (k == 1) ? 5'h0F : (k == 2) ? 5'h15 : 5'h1F;
         wr(A_DIR, {3'b000, dpat});
         for (int p = 0; p < 32; p++) begin
            @(negedge clk);
            pin_in = 5'(p);
            repeat (3) @(negedge clk);
            rd(A_PIN, rv);
            check("R7 pin view", {24'd0, rv},
                  {24'd0, 3'b000, (dpat & 5'h0A) | (~dpat & 5'(p))});
         end
      end

      // R7: synchronizer delay on input pins
      wr(A_DIR, 8'h00);
      @(negedge clk);
      pin_in = 5'h00;
      repeat (3) @(negedge clk);
      pin_in = 5'h1B;
      rd(A_PIN, rv);
      check("R7 sync delay old value", {24'd0, rv}, 32'h00);
      rd(A_PIN, rv);
      check("R7 sync delay new value", {24'd0, rv}, 32'h1B);

      // R2: manual reset keeps direction bit 4, clears the rest
      do_por(3'd4);
      wr(A_DIR, 8'h1F);
      wr(A_DAT, 8'h15);
      @(negedge clk);
      man_rst = 1'b1; bus_addr = A_DIR; bus_wdata = 8'h00; bus_wr = 1'b1;
      @(negedge clk);
      man_rst = 1'b0; bus_wr = 1'b0;
      check("R2 manual reset keeps bit 4", {27'd0, pin_oe}, 32'h10);
      rd(A_DAT, rv);
      check("R2 manual reset clears data", {24'd0, rv}, 32'h00);
      do_por(3'd2);
      check("R1 mode 2 bit4 clear", {27'd0, pin_oe}, 32'h00);
      wr(A_DIR, 8'h10);
      @(negedge clk);
      man_rst = 1'b1;
      @(negedge clk);
      man_rst = 1'b0;
      check("R2 written bit4 kept", {27'd0, pin_oe}, 32'h10);

      // R6: chip-select takeover of pin 4
      do_por(3'd1);
      wr(A_DAT, 8'h10);
      @(negedge clk); bus_cs_n = 1'b0;
      @(negedge clk);
      check("R6 cs low on pin4", {31'd0, pin_out[4]}, 32'd0);
      check("R6 oe4 in ext mode", {31'd0, pin_oe[4]}, 32'd1);
      bus_cs_n = 1'b1;
      @(negedge clk);
      check("R6 cs high on pin4", {31'd0, pin_out[4]}, 32'd1);
      wr(A_DAT, 8'h00);
      check("R6 data ignored while cs", {31'd0, pin_out[4]}, 32'd1);
      wr(A_DIR, 8'h00);
      check("R6 dir4 clear gives input", {31'd0, pin_oe[4]}, 32'd0);
      check("R6 dir4 clear out is data", {31'd0, pin_out[4]}, 32'd0);
      do_por(3'd7);
      wr(A_DIR, 8'h10);
      wr(A_DAT, 8'h10);
      @(negedge clk); bus_cs_n = 1'b0;
      @(negedge clk);
      check("R6 mode7 pin4 from data", {31'd0, pin_out[4]}, 32'd1);
      bus_cs_n = 1'b1;

      // R9: read and write of the same register in one cycle
      wr(A_DAT, 8'h03);
      @(negedge clk);
      bus_addr = A_DAT; bus_wdata = 8'h1C; bus_wr = 1'b1; bus_rd = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      check("R9 same-cycle read old", {24'd0, bus_rdata}, 32'h03);
      rd(A_DAT, rv);
      check("R9 next read new", {24'd0, rv}, 32'h1C);

      // R10 R8: unmapped addresses
      wr(A_DIR, 8'h05);
      wr(16'hFF70, 8'hFF);
      wr(16'h0000, 8'hFF);
      check("R10 oe unchanged", {27'd0, pin_oe}, 32'h05);
      check("R10 out unchanged", {27'd0, pin_out}, 32'h1C);
      rd(A_DAT, rv);
      check("R10 data unchanged", {24'd0, rv}, 32'h1C);
      rd(16'hFF70, rv);
      check("R8 unmapped read zero", {24'd0, rv}, 32'h00);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule